// File: doc/BRIEF.md
# I2C Bus Line Recovery Sequencer

This block brings an I2C controller out of a state in which its busy indication is stuck, although both bus lines really sit idle high. Once a recovery request is accepted, it first turns the controller off. It then takes the SCL and SDA pins under direct open-drain control. It walks the lines through a fixed pattern, a START-like fall of SDA followed by a STOP-like rise, and reads each line back after every change. At the end it returns the pins to the controller, pulses the controller's soft reset and turns the controller on again.

Each line input passes through a two-flop synchronizer before it is compared. Three control inputs set the timing. The first sets how long each drive change settles before sampling. The second sets how long a readback may wait for the expected level. The third sets the width of the soft-reset pulse. If a readback does not show the expected level in time, the sequencer releases both lines and gives the pins back to the controller. It leaves the controller disabled and raises a sticky error flag instead of the done pulse. All interfaces are plain control and status pins. No data flows through the block, so it has no valid/ready handshake and nothing to back-pressure.

Top module: `i2c_bus_recover`

## Requirements
- R1: Out of reset, periph_en_o is 1, and pin_gpio_o, scl_oe_o, sda_oe_o, soft_rst_o, done_o and err_o are all 0.
- R2: A start_i sampled high while idle is accepted. In the next cycle periph_en_o is 0, and pin_gpio_o and both drive enables are still 0.
- R3: While pin_gpio_o is 1, the drive pair {scl_oe_o, sda_oe_o} (1 = pull low) steps through exactly 00, 01, 11, 01, 00 in that order. scl_oe_o is never 1 while sda_oe_o is 0.
- R4: Each step holds its drive for H = max(cfg_hold_i, 2) cycles. The step then samples the synchronized pair {SCL, SDA}, which must equal the inverse of the step's drive pair.
- R5: A step whose readback stays wrong for cfg_timeout_i + 1 check cycles aborts. For a failure at step k, err_o rises in cycle k(H+1)+H+cfg_timeout_i+3, where cycle 1 is the first cycle after acceptance. After the abort, pin_gpio_o and both drive enables are 0, periph_en_o stays 0, and done_o does not pulse.
- R6: err_o stays high until the next accepted start, and it reads 0 in the first cycle after that acceptance.
- R7: Once the pins are returned, soft_rst_o is high for exactly max(cfg_rstlen_i, 1) consecutive cycles. During that pulse pin_gpio_o and periph_en_o are both 0.
- R8: With no fault, done_o pulses for one cycle, in cycle 5H + max(cfg_rstlen_i,1) + 9. periph_en_o rises in that same cycle.
- R9: start_i is ignored whenever the sequencer is not idle, including the cycle in which done_o pulses. Such a pulse does not lengthen or restart the sequence.
- R10: periph_en_o is 0 in every cycle in which pin_gpio_o or soft_rst_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery request, sampled while idle |
| cfg_hold_i | input | CW | Settle cycles after each drive change (minimum 2 applied) |
| cfg_timeout_i | input | CW | Extra check cycles allowed per readback |
| cfg_rstlen_i | input | CW | Soft-reset pulse width (minimum 1 applied) |
| scl_in_i | input | 1 | Raw SCL pin level |
| sda_in_i | input | 1 | Raw SDA pin level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| pin_gpio_o | output | 1 | 1 = pins under direct control, 0 = pins with controller |
| periph_en_o | output | 1 | Controller enable |
| soft_rst_o | output | 1 | Controller soft reset |
| done_o | output | 1 | Single-cycle recovery complete pulse |
| err_o | output | 1 | Sticky recovery failure flag |

## Verification
Two pairs of events can fall in one cycle. The first is a fresh start request landing in the very cycle in which done_o pulses and the enable is restored. The bench raises start_i in exactly that cycle on every fault-free run. It judges the result by periph_en_o staying high and the pins staying with the controller afterwards. The second is a readback deadline expiring in the same cycle as a settle count. The bench sweeps settle time, timeout and reset width over small ranges, with five kinds of line faults, each placed at a different step. The bench computes the done or error cycle arithmetically and compares it with the cycle it observes.

// File: rtl/i2c_rec_pkg.sv
package i2c_rec_pkg;

  localparam int NSTEP  = 5;
  localparam int STEP_W = $clog2(NSTEP);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIS,
    ST_HOLD,
    ST_CHECK,
    ST_BACK,
    ST_RST,
    ST_RCLR,
    ST_EN,
    ST_FAIL
  } rec_state_e;

  // Drive pair {scl_pull, sda_pull} for each step; 1 pulls the line low.
  function automatic logic [1:0] step_drive(input logic [STEP_W-1:0] s);
    case (s)
      STEP_W'(1): step_drive = 2'b01;
      STEP_W'(2): step_drive = 2'b11;
      STEP_W'(3): step_drive = 2'b01;
      default:    step_drive = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/irs_sync2.sv
module irs_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // Bus idles high, so both stages reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irs_timer.sv
module irs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/irs_fsm.sv
module irs_fsm
  import i2c_rec_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] hold_eff_i,
  input  logic [CW-1:0] timeout_i,
  input  logic [CW-1:0] rstlen_eff_i,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          pin_gpio_o,
  output logic          periph_en_o,
  output logic          soft_rst_o,
  output logic          done_o,
  output logic          err_o
);
  rec_state_e        st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              en_q, en_d;
  logic              err_q, err_d;
  logic [1:0]        drive;
  logic              match;
  logic              last_step;

  assign drive     = step_drive(step_q);
  assign match     = ({scl_s_i, sda_s_i} == ~drive);
  assign last_step = (step_q == STEP_W'(NSTEP - 1));

  always_comb begin
    st_d       = st_q;
    step_d     = step_q;
    en_d       = en_q;
    err_d      = err_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d  = ST_DIS;
          en_d  = 1'b0;
          err_d = 1'b0;
        end
      end
      ST_DIS: begin
        st_d       = ST_HOLD;
        step_d     = '0;
        tmr_load_o = 1'b1;
        tmr_val_o  = hold_eff_i - CW'(1);
      end
      ST_HOLD: begin
        if (tmr_zero_i) begin
          st_d       = ST_CHECK;
          tmr_load_o = 1'b1;
          tmr_val_o  = timeout_i;
        end
      end
      ST_CHECK: begin
        if (match) begin
          if (last_step) begin
            st_d = ST_BACK;
          end else begin
            st_d       = ST_HOLD;
            step_d     = step_q + STEP_W'(1);
            tmr_load_o = 1'b1;
            tmr_val_o  = hold_eff_i - CW'(1);
          end
        end else if (tmr_zero_i) begin
          st_d  = ST_FAIL;
          err_d = 1'b1;
        end
      end
      ST_BACK: begin
        st_d       = ST_RST;
        tmr_load_o = 1'b1;
        tmr_val_o  = rstlen_eff_i - CW'(1);
      end
      ST_RST: begin
        if (tmr_zero_i) st_d = ST_RCLR;
      end
      ST_RCLR: begin
        st_d = ST_EN;
        en_d = 1'b1;
      end
      ST_EN:   st_d = ST_IDLE;
      ST_FAIL: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      en_q   <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      en_q   <= en_d;
      err_q  <= err_d;
    end
  end

  logic on_pins;
  assign on_pins     = (st_q == ST_HOLD) || (st_q == ST_CHECK);
  assign pin_gpio_o  = on_pins;
  assign scl_oe_o    = on_pins & drive[1];
  assign sda_oe_o    = on_pins & drive[0];
  assign soft_rst_o  = (st_q == ST_RST);
  assign done_o      = (st_q == ST_EN);
  assign periph_en_o = en_q;
  assign err_o       = err_q;
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int CW       = 8,
  parameter int HOLD_MIN = 2,
  parameter int RST_MIN  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] cfg_hold_i,
  input  logic [CW-1:0] cfg_timeout_i,
  input  logic [CW-1:0] cfg_rstlen_i,
  input  logic          scl_in_i,
  input  logic          sda_in_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          pin_gpio_o,
  output logic          periph_en_o,
  output logic          soft_rst_o,
  output logic          done_o,
  output logic          err_o
);
  localparam logic [CW-1:0] HOLD_FLOOR = CW'(HOLD_MIN);
  localparam logic [CW-1:0] RST_FLOOR  = CW'(RST_MIN);

  logic [CW-1:0] hold_eff;
  logic [CW-1:0] rstlen_eff;
  logic [1:0]    lines_s;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;

  // Floors keep the synchronizer latency inside the settle window.
  assign hold_eff   = (cfg_hold_i   < HOLD_FLOOR) ? HOLD_FLOOR : cfg_hold_i;
  assign rstlen_eff = (cfg_rstlen_i < RST_FLOOR)  ? RST_FLOOR  : cfg_rstlen_i;

  irs_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_in_i, sda_in_i}),
    .q_o   (lines_s)
  );

  irs_timer #(.CW(CW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  irs_fsm #(.CW(CW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .hold_eff_i   (hold_eff),
    .timeout_i    (cfg_timeout_i),
    .rstlen_eff_i (rstlen_eff),
    .scl_s_i      (lines_s[1]),
    .sda_s_i      (lines_s[0]),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .pin_gpio_o   (pin_gpio_o),
    .periph_en_o  (periph_en_o),
    .soft_rst_o   (soft_rst_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );
endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic pin_gpio_o,
  input logic periph_en_o,
  input logic soft_rst_o,
  input logic done_o,
  input logic err_o
);
  // R10: controller disabled while pins are taken or reset is pulsed
  p_en_off_gpio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_gpio_o |-> !periph_en_o);

  // R7: soft reset only with pins back and controller off
  p_rst_pins_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (!pin_gpio_o && !periph_en_o));

  // R3: drives only under direct pin control; SCL never pulled while SDA released
  p_drive_gpio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe_o || sda_oe_o) |-> pin_gpio_o);
  p_sda_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe_o |-> sda_oe_o);

  // R8: done coincides with enable rising and lasts one cycle
  p_done_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $rose(periph_en_o));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: error stays set unless a start is presented
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);

  // R5: error and done never together
  p_err_no_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !done_o);
endmodule

bind i2c_bus_recover i2c_bus_recover_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .scl_oe_o    (scl_oe_o),
  .sda_oe_o    (sda_oe_o),
  .pin_gpio_o  (pin_gpio_o),
  .periph_en_o (periph_en_o),
  .soft_rst_o  (soft_rst_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/tb_i2c_bus_recover.sv
`timescale 1ns/1ps
module tb_i2c_bus_recover;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] cfg_hold = '0, cfg_to = '0, cfg_rl = '0;
  logic scl_oe, sda_oe, pin_gpio, periph_en, soft_rst, done, err;
  logic scl_line, sda_line;
  int   mode = 0;          // 0 none,1 scl low,2 sda high,3 scl high,4 scl latch low,5 sda latch low
  logic clr_latch = 1'b0;
  logic scl_latch, sda_latch;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr_latch) begin
      scl_latch <= 1'b0;
      sda_latch <= 1'b0;
    end else begin
      if (mode == 4 && scl_oe) scl_latch <= 1'b1;
      if (mode == 5 && sda_oe) sda_latch <= 1'b1;
    end
  end

  assign scl_line = (mode == 1 || scl_latch) ? 1'b0 : (mode == 3) ? 1'b1 : ~scl_oe;
  assign sda_line = sda_latch ? 1'b0 : (mode == 2) ? 1'b1 : ~sda_oe;

  i2c_bus_recover #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .cfg_hold_i(cfg_hold), .cfg_timeout_i(cfg_to), .cfg_rstlen_i(cfg_rl),
    .scl_in_i(scl_line), .sda_in_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .pin_gpio_o(pin_gpio),
    .periph_en_o(periph_en), .soft_rst_o(soft_rst), .done_o(done), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One recovery attempt; fail_step < 0 means a clean run is expected.
  task automatic run(input int hold, input int rl, input int to, input int md, input int fail_step);
    int h, r, exp_c, done_c, err_c, ndone, rst_w, viol, pat, npat;
    logic [1:0] last;
    bit in_gpio;
    h = (hold < 2) ? 2 : hold;
    r = (rl < 1) ? 1 : rl;
    @(negedge clk);
    cfg_hold = CW'(hold); cfg_rl = CW'(rl); cfg_to = CW'(to);
    mode = 0; clr_latch = 1'b1;
    repeat (3) @(negedge clk);
    clr_latch = 1'b0; mode = md;
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    done_c = 0; err_c = 0; ndone = 0; rst_w = 0; viol = 0; pat = 0; npat = 0;
    last = 2'b00; in_gpio = 1'b0;
    exp_c = (fail_step < 0) ? 5*h + r + 9 : fail_step*(h+1) + h + to + 3;
    for (int c = 1; c <= exp_c + 5; c++) begin
      if (c == 1) begin
        check(periph_en == 0 && pin_gpio == 0 && scl_oe == 0 && sda_oe == 0, "R2",
              {periph_en, pin_gpio, scl_oe, sda_oe}, 0);
        check(err == 0, "R6 cleared on start", err, 0);
      end
      if (pin_gpio) begin
        if (!in_gpio || {scl_oe, sda_oe} != last) begin
          pat = (pat << 2) | {scl_oe, sda_oe};
          npat++;
        end
        in_gpio = 1'b1;
        last = {scl_oe, sda_oe};
      end
      if ((pin_gpio || soft_rst) && periph_en) viol++;
      if (soft_rst && pin_gpio) viol++;
      if (soft_rst) rst_w++;
      if (done) begin ndone++; if (done_c == 0) done_c = c; end
      if (err && err_c == 0) err_c = c;
      if (done && fail_step < 0) begin
        check(periph_en == 1, "R8 enable with done", periph_en, 1);
        start = 1'b1;            // R9: request lands on the done cycle
      end else begin
        start = 1'b0;
      end
      if (c == 3) start = 1'b1;   // R9: request mid-run
      if (c == 4) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(viol == 0, "R10 enable off during pin control/reset", viol, 0);
    if (fail_step < 0) begin
      check(done_c == exp_c, "R4/R8 done cycle", done_c, exp_c);
      check(ndone == 1, "R9 single done", ndone, 1);
      check(rst_w == r, "R7 reset width", rst_w, r);
      check(npat == 5 && pat == 'h074, "R3 drive order", pat, 'h074);
      check(periph_en == 1 && pin_gpio == 0, "R9 no restart", {periph_en, pin_gpio}, 2);
      check(err == 0, "R6 no error", err, 0);
    end else begin
      check(err_c == exp_c, "R5 error cycle", err_c, exp_c);
      check(ndone == 0 && rst_w == 0, "R5 no done/reset", ndone + rst_w, 0);
      check(periph_en == 0 && pin_gpio == 0 && scl_oe == 0 && sda_oe == 0, "R5 released",
            {periph_en, pin_gpio, scl_oe, sda_oe}, 0);
      repeat (4) @(negedge clk);
      check(err == 1, "R6 sticky", err, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(periph_en == 1 && pin_gpio == 0 && scl_oe == 0 && sda_oe == 0 &&
          soft_rst == 0 && done == 0 && err == 0, "R1 in reset",
          {periph_en, pin_gpio, scl_oe, sda_oe, soft_rst, done, err}, 64);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(periph_en == 1 && pin_gpio == 0 && err == 0 && done == 0, "R1 after reset",
          {periph_en, pin_gpio, err, done}, 8);
    for (int h = 0; h <= 4; h++)
      for (int r = 0; r <= 3; r++)
        run(h, r, 1, 0, -1);
    for (int m = 1; m <= 5; m++)
      for (int t = 0; t <= 2; t++)
        for (int h = 2; h <= 3; h++) begin
          run(h, 1, t, m, m - 1);
          run(h, 2, t, 0, -1);   // next start clears the error
        end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule